// File: doc/BRIEF.md
# Two-Threshold Undervoltage Lockout Controller

This block turns two comparator decisions about the supply rail into one supply-good state. Each comparator output is high while the supply sits above that comparator's own programmable level. Both outputs arrive asynchronously. Each one is synchronized and then debounced before the block evaluates it. The state is set only when both comparators see the supply above their levels. It is cleared only when both see it below. While the comparators disagree, the supply is inside the band between the two levels and the state holds its value. The two levels therefore form a hysteresis window that tolerates droop under load.

A small byte-wide register interface configures the block. One configuration byte holds both level codes, which go straight out to the comparators. An enable byte gates the interrupt, and a status byte reports the live state and a sticky interrupt flag. Every good-to-bad transition sets the flag and emits a one-cycle shutdown request. When the enable is set, the flag pulls the active-low interrupt line. The start-up permit follows the state.

Top module: `uvlo_ctrl`

## Requirements
- R1: After reset the state, the permit output, the shutdown request and the interrupt flag are 0 and irq_n is 1. The configuration byte reads 0x53 and the enable byte reads 0.
- R2: When both filtered comparators report the supply above their levels, the state becomes 1 and permit_o goes high.
- R3: When both filtered comparators report the supply below their levels, the state becomes 0 and permit_o goes low.
- R4: When the two filtered comparators disagree, the state keeps its previous value, whether that value is 0 or 1.
- R5: A comparator level must persist for DEB_LEN (default 3) consecutive synchronized cycles before it is accepted. A 2-cycle pulse on the inputs has no effect, and a 3-cycle pulse on both inputs is accepted.
- R6: Each 1-to-0 transition of the state sets the interrupt flag and pulses shutdown_req_o high for exactly one cycle. A 0-to-1 transition does neither.
- R7: Writing a byte with bit 0 set to the status address 0x8E clears the flag. Writing bit 0 as 0 leaves the flag unchanged.
- R8: irq_n_o is low exactly when the flag is 1 and bit 0 of the enable byte at address 0x86 is 1.
- R9: The configuration byte at address 0x85 is read/write. Bits [3:0] drive thr_a_o and bits [7:4] drive thr_b_o.
- R10: The status byte at 0x8E reads the state in bit 2 and the flag in bit 0, with all other bits 0. Writes cannot change bit 2. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_a_i | input | 1 | Comparator A: 1 = supply above level A (asynchronous) |
| cmp_b_i | input | 1 | Comparator B: 1 = supply above level B (asynchronous) |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational on address) |
| thr_a_o | output | 4 | Level code for comparator A |
| thr_b_o | output | 4 | Level code for comparator B |
| permit_o | output | 1 | Start-up and operation permitted |
| shutdown_req_o | output | 1 | One-cycle request on loss of supply-good |
| irq_n_o | output | 1 | Active-low interrupt |

## Verification
The combining rule is driven through an ordered walk of comparator pairs. The walk covers both-above, each single-comparator disagreement reached from a good state and from a bad state, and both-below. This separates a true hold from a plain AND or OR of the inputs. Pulses of 2 and 3 cycles test the debounce boundary. The count and width of the shutdown pulses, together with the flag after a rising transition, distinguish a fall-only edge detector from a level detector or a detector that fires on any change.

// File: rtl/uvlo_pkg.sv
package uvlo_pkg;
  localparam int unsigned CH_N  = 2;
  localparam int unsigned ADR_W = 8;
  localparam int unsigned DAT_W = 8;

  localparam logic [ADR_W-1:0] ADDR_CFG  = 8'h85;
  localparam logic [ADR_W-1:0] ADDR_IEN  = 8'h86;
  localparam logic [ADR_W-1:0] ADDR_STAT = 8'h8E;

  localparam int unsigned STAT_FLAG_BIT  = 0;
  localparam int unsigned STAT_STATE_BIT = 2;

  localparam logic [DAT_W-1:0] CFG_RESET = 8'h53;

  // window rule: set when both above, clear when both below, else hold
  function automatic logic uvlo_next(input logic above_a, input logic above_b,
                                     input logic cur);
    if (above_a && above_b)   return 1'b1;
    if (!above_a && !above_b) return 1'b0;
    return cur;
  endfunction

  // status byte assembly
  function automatic logic [DAT_W-1:0] stat_pack(input logic state, input logic flag);
    logic [DAT_W-1:0] v;
    v = '0;
    v[STAT_STATE_BIT] = state;
    v[STAT_FLAG_BIT]  = flag;
    return v;
  endfunction
endpackage

// File: rtl/uvlo_sync_deb.sv
module uvlo_sync_deb #(
  parameter int unsigned DEB_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic filt_o
);
  localparam int unsigned CNT_W = $clog2(DEB_LEN) + 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEB_LEN - 1);

  logic s1_q, s2_q, filt_q;
  logic [CNT_W-1:0] cnt_q;
  logic mismatch;

  assign mismatch = (s2_q != filt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= raw_i;
      s2_q <= s1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q <= 1'b0;
      cnt_q  <= '0;
    end else if (mismatch) begin
      if (cnt_q == CNT_LAST) begin
        filt_q <= s2_q;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
    end
  end

  assign filt_o = filt_q;
endmodule

// File: rtl/uvlo_state.sv
module uvlo_state
  import uvlo_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CH_N-1:0] above_i,
  output logic            state_o,
  output logic            fall_o,
  output logic            shut_o
);
  logic state_q, state_d, shut_q;

  assign state_d = uvlo_next(above_i[0], above_i[1], state_q);
  assign fall_o  = state_q && !state_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= 1'b0;
      shut_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      shut_q  <= fall_o;
    end
  end

  assign state_o = state_q;
  assign shut_o  = shut_q;
endmodule

// File: rtl/uvlo_regs.sv
module uvlo_regs
  import uvlo_pkg::*;
#(
  parameter int unsigned THR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [ADR_W-1:0] addr_i,
  input  logic [DAT_W-1:0] wdata_i,
  output logic [DAT_W-1:0] rdata_o,
  input  logic             state_i,
  input  logic             fall_i,
  output logic [THR_W-1:0] thr_a_o,
  output logic [THR_W-1:0] thr_b_o,
  output logic             flag_o,
  output logic             ien_o,
  output logic             irq_n_o
);
  logic [DAT_W-1:0] cfg_q;
  logic flag_q, ien_q;
  logic wr_cfg, wr_ien, wr_stat;
  logic unused_wbits;

  assign wr_cfg  = wr_i && (addr_i == ADDR_CFG);
  assign wr_ien  = wr_i && (addr_i == ADDR_IEN);
  assign wr_stat = wr_i && (addr_i == ADDR_STAT);
  assign unused_wbits = ^wdata_i[DAT_W-1:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= CFG_RESET;
    else if (wr_cfg) cfg_q <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ien_q <= 1'b0;
    else if (wr_ien) ien_q <= wdata_i[0];
  end

  // set has priority over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else if (fall_i) flag_q <= 1'b1;
    else if (wr_stat && wdata_i[STAT_FLAG_BIT]) flag_q <= 1'b0;
  end

  always_comb begin
    unique case (addr_i)
      ADDR_CFG:  rdata_o = cfg_q;
      ADDR_IEN:  rdata_o = {{(DAT_W-1){1'b0}}, ien_q};
      ADDR_STAT: rdata_o = stat_pack(state_i, flag_q);
      default:   rdata_o = '0;
    endcase
  end

  assign thr_a_o = cfg_q[THR_W-1:0];
  assign thr_b_o = cfg_q[2*THR_W-1:THR_W];
  assign flag_o  = flag_q;
  assign ien_o   = ien_q;
  assign irq_n_o = !(flag_q && ien_q);
endmodule

// File: rtl/uvlo_ctrl.sv
module uvlo_ctrl
  import uvlo_pkg::*;
#(
  parameter int unsigned DEB_LEN = 3,
  parameter int unsigned THR_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_a_i,
  input  logic             cmp_b_i,
  input  logic             reg_wr_i,
  input  logic [ADR_W-1:0] reg_addr_i,
  input  logic [DAT_W-1:0] reg_wdata_i,
  output logic [DAT_W-1:0] reg_rdata_o,
  output logic [THR_W-1:0] thr_a_o,
  output logic [THR_W-1:0] thr_b_o,
  output logic             permit_o,
  output logic             shutdown_req_o,
  output logic             irq_n_o
);
  logic [CH_N-1:0] raw;
  logic [CH_N-1:0] filt;
  logic state, fall, flag, ien;

  assign raw = {cmp_b_i, cmp_a_i};

  for (genvar g = 0; g < CH_N; g++) begin : g_ch
    uvlo_sync_deb #(.DEB_LEN(DEB_LEN)) u_deb (
      .clk(clk), .rst_n(rst_n), .raw_i(raw[g]), .filt_o(filt[g])
    );
  end

  uvlo_state u_state (
    .clk(clk), .rst_n(rst_n), .above_i(filt),
    .state_o(state), .fall_o(fall), .shut_o(shutdown_req_o)
  );

  uvlo_regs #(.THR_W(THR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o), .state_i(state),
    .fall_i(fall), .thr_a_o(thr_a_o), .thr_b_o(thr_b_o),
    .flag_o(flag), .ien_o(ien), .irq_n_o(irq_n_o)
  );

  assign permit_o = state;
endmodule

// File: rtl/uvlo_chk.sv
module uvlo_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] filt,
  input logic       state,
  input logic       flag,
  input logic       ien,
  input logic       irq_n,
  input logic       shut,
  input logic       permit
);
  AST_BOTH_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (filt[0] && filt[1]) |=> state); // R2
  AST_BOTH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!filt[0] && !filt[1]) |=> !state); // R3
  AST_HOLD_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (filt[0] != filt[1]) |=> $stable(state)); // R4
  AST_FALL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(state) |-> (flag && shut)); // R6
  AST_SHUT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    shut |=> !shut); // R6
  AST_RISE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state) |-> !shut); // R6
  AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (flag && ien)); // R8
  AST_PERMIT_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    permit == state); // R2
endmodule

bind uvlo_ctrl uvlo_chk u_chk (
  .clk(clk), .rst_n(rst_n), .filt(filt), .state(state), .flag(flag),
  .ien(ien), .irq_n(irq_n_o), .shut(shutdown_req_o), .permit(permit_o)
);

// File: tb/sim_uvlo_ctrl.sv
`timescale 1ns/1ps
module sim_uvlo_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmp_a = 1'b0, cmp_b = 1'b0;
  logic wr = 1'b0;
  logic [7:0] addr = 8'h00, wdata = 8'h00;
  logic [7:0] rdata;
  logic [3:0] thr_a, thr_b;
  logic permit, shut, irq_n;

  int total = 0, fails = 0;
  int pulses = 0, run = 0, maxrun = 0;

  always #2.5 clk = ~clk;

  uvlo_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cmp_a_i(cmp_a), .cmp_b_i(cmp_b),
    .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .thr_a_o(thr_a), .thr_b_o(thr_b),
    .permit_o(permit), .shutdown_req_o(shut), .irq_n_o(irq_n)
  );

  // {a, b} pairs walked in order; expected state is derived below
  localparam int NV = 8;
  localparam logic [1:0] VEC [NV] = '{2'b11, 2'b10, 2'b01, 2'b00,
                                      2'b10, 2'b01, 2'b11, 2'b00};

  function automatic logic model_next(input logic [1:0] ab, input logic prev);
    case (ab)
      2'b11:   return 1'b1;
      2'b00:   return 1'b0;
      default: return prev;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wrb(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic settle();
    repeat (10) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (shut) begin
        if (run == 0) pulses++;
        run++;
        if (run > maxrun) maxrun = run;
      end else begin
        run = 0;
      end
    end
  end

  initial begin
    #400000;
    fails++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic exp_state;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 permit", permit, 0);
    check("R1 irq_n", irq_n, 1);
    check("R1 shutdown", shut, 0);
    rd(8'h8E, d); check("R1 status", d, 8'h00);
    rd(8'h85, d); check("R1 cfg", d, 8'h53);
    rd(8'h86, d); check("R1 enable", d, 8'h00);

    // R2 R3 R4 table walk
    exp_state = 1'b0;
    for (int i = 0; i < NV; i++) begin
      cmp_a = VEC[i][1]; cmp_b = VEC[i][0];
      exp_state = model_next(VEC[i], exp_state);
      settle();
      check(VEC[i] == 2'b11 ? "R2 both above" :
            VEC[i] == 2'b00 ? "R3 both below" : "R4 window hold",
            permit, exp_state);
      rd(8'h8E, d);
      check("R10 status state bit", d[2], exp_state);
    end

    // R6 flag after falls, R8 masked
    rd(8'h8E, d); check("R6 flag set on fall", d[0], 1);
    check("R8 irq masked", irq_n, 1);
    wrb(8'h86, 8'h01);
    check("R8 irq asserted", irq_n, 0);
    wrb(8'h8E, 8'h04);
    rd(8'h8E, d); check("R10 write bit2 ignored / R7 zero write keeps flag", d, 8'h01);
    wrb(8'h8E, 8'h01);
    rd(8'h8E, d); check("R7 flag cleared", d[0], 0);
    check("R8 irq released", irq_n, 1);

    // R5 debounce boundary
    @(negedge clk); cmp_a = 1; cmp_b = 1;
    repeat (2) @(negedge clk); cmp_a = 0; cmp_b = 0;
    settle();
    check("R5 short pulse state", permit, 0);
    rd(8'h8E, d); check("R5 short pulse flag", d[0], 0);
    @(negedge clk); cmp_a = 1; cmp_b = 1;
    repeat (3) @(negedge clk); cmp_a = 0; cmp_b = 0;
    settle();
    rd(8'h8E, d); check("R5 3-cycle pulse accepted", d, 8'h01);
    wrb(8'h8E, 8'hFF);

    // R6 rising transition leaves flag clear
    cmp_a = 1; cmp_b = 1;
    settle();
    check("R2 permit high", permit, 1);
    rd(8'h8E, d); check("R6 no flag on rise / R10 status", d, 8'h04);
    check("R8 irq idle", irq_n, 1);

    // R9 configuration
    wrb(8'h85, 8'hA7);
    rd(8'h85, d); check("R9 cfg readback", d, 8'hA7);
    check("R9 thr_a", thr_a, 4'h7);
    check("R9 thr_b", thr_b, 4'hA);
    rd(8'h10, d); check("R10 unmapped read", d, 8'h00);

    // R6 shutdown pulses: falls at table steps 4 and 8, plus the 3-cycle pulse
    check("R6 shutdown pulse count", pulses, 3);
    check("R6 shutdown pulse width", maxrun, 1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule